// File: doc/BRIEF.md
# Timer Output Pin Level Controller

This block sets the level of one timer output pin from events that a counter and its comparators report elsewhere in the timer. It has three active modes. In compare mode, a match from comparator A applies a small action to the pin: keep it, force it low, force it high, or invert it. In pulse-width mode, a period match starts the active phase and a duty match ends it. In single-pulse mode, a pulse opens when the enable bit rises and closes on a comparator-A match. In the fourth mode the timer only counts, and the pin is not driven.

A configuration bit `lvl_cfg_i` has a different meaning in each mode. In compare mode it is the starting level. In pulse-width mode it is the polarity of the active phase. In single-pulse mode it is the level taken when the enable bit rises. A rising edge of the enable bit reloads the starting level in compare mode. The action field is sampled only while the enable bit is low. A timer that is already running therefore keeps the action it was armed with. The pin is a register, and every input shows its effect on the next rising clock edge.

Top module: `tpc_pin_ctrl`

## Requirements
- R1: With mode code 00 (count only), the pin is held at IDLE_LEVEL (default 0) whatever the other inputs do.
- R2: With mode code 01 (compare), a cycle in which `run_i` is 1 after being 0 loads the pin with `lvl_cfg_i`. This takes priority over a match in the same cycle.
- R3: In compare mode, with `run_i` high and no enable edge, a comparator-A match applies the latched action: 00 keeps the pin, 01 drives it to 0, 10 drives it to 1, 11 inverts it.
- R4: In compare mode, a drive-high or drive-low action that asks for the level the pin already has leaves the pin unchanged.
- R5: In compare mode with `run_i` low, the pin holds its level and matches are ignored.
- R6: `act_i` is captured only on clock edges where `run_i` is low. A change made while `run_i` is high does not affect matches until `run_i` has gone low.
- R7: With mode code 10 (pulse-width), a period match enters the active phase and a duty match leaves it. When both arrive in one cycle, the duty match wins (DUTY_WINS=1). The pin shows `lvl_cfg_i` in the active phase and its inverse otherwise, so 1 means active high and 0 means active low.
- R8: In pulse-width mode with `run_i` low, the phase is inactive and the pin shows the inverse of `lvl_cfg_i`.
- R9: With mode code 11 (single pulse), an enable edge sets the pin to `lvl_cfg_i`. A comparator-A match while enabled sets it to the inverse. `run_i` low holds it at the inverse.
- R10: After reset the pin is 0 and the latched action is 00.
- R11: The pin changes only at a rising clock edge. The effect of inputs applied before an edge appears after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 count only, 01 compare, 10 pulse-width, 11 single pulse |
| act_i | input | 2 | Compare action: 00 keep, 01 low, 10 high, 11 invert |
| lvl_cfg_i | input | 1 | Starting level, polarity or pulse level, depending on mode |
| run_i | input | 1 | Timer enable bit |
| cmpa_hit_i | input | 1 | Comparator-A match strobe |
| duty_hit_i | input | 1 | Duty match strobe (pulse-width mode) |
| period_hit_i | input | 1 | Period match strobe (pulse-width mode) |
| pin_o | output | 1 | Output pin level |

## Verification
Directed sequences cover each case on its own:
- every compare action applied from both starting levels, which shows whether a set action that repeats the current level is really a no-op;
- enable edges arriving together with matches, which shows the priority order;
- an action change made while running, which separates the latched action from the live one;
- coincident duty and period matches at both polarities.

Long random runs then switch modes, enable levels and strobes freely. These runs expose state that leaks between modes and toggle chains against a bench model built from the requirements.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
   localparam int MODE_W = 2;
   localparam int ACT_W  = 2;

   typedef enum logic [MODE_W-1:0] {
      PM_COUNT   = 2'b00,
      PM_COMPARE = 2'b01,
      PM_PWM     = 2'b10,
      PM_PULSE   = 2'b11
   } pin_mode_e;

   typedef enum logic [ACT_W-1:0] {
      ACT_KEEP = 2'b00,
      ACT_LOW  = 2'b01,
      ACT_HIGH = 2'b10,
      ACT_FLIP = 2'b11
   } pin_act_e;
endpackage

// File: rtl/tpc_cfg_track.sv
// Tracks the enable bit and arms the compare action while idle.
module tpc_cfg_track
   import tpc_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [ACT_W-1:0] act_i,
   output pin_act_e         act_q_o,
   output logic             run_rise_o
);
   logic     run_q;
   pin_act_e act_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         act_q <= ACT_KEEP;
      end else begin
         run_q <= run_i;
         if (!run_i) begin
            act_q <= pin_act_e'(act_i);
         end
      end
   end

   assign run_rise_o = run_i & ~run_q;
   assign act_q_o    = act_q;
endmodule

// File: rtl/tpc_pwm_phase.sv
// Active-phase tracker for pulse-width mode.
module tpc_pwm_phase #(
   parameter bit DUTY_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic live_i,
   input  logic duty_hit_i,
   input  logic period_hit_i,
   output logic on_nxt_o
);
   logic on_q;
   logic on_step;

   generate
      if (DUTY_WINS) begin : g_duty_first
         always_comb begin
            if (duty_hit_i)        on_step = 1'b0;
            else if (period_hit_i) on_step = 1'b1;
            else                   on_step = on_q;
         end
      end else begin : g_period_first
         always_comb begin
            if (period_hit_i)      on_step = 1'b1;
            else if (duty_hit_i)   on_step = 1'b0;
            else                   on_step = on_q;
         end
      end
   endgenerate

   assign on_nxt_o = live_i & on_step;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) on_q <= 1'b0;
      else         on_q <= on_nxt_o;
   end
endmodule

// File: rtl/tpc_level_sel.sv
// Next pin level for each mode.
module tpc_level_sel
   import tpc_pkg::*;
#(
   parameter bit IDLE_LEVEL = 1'b0
) (
   input  pin_mode_e mode_i,
   input  logic      lvl_cfg_i,
   input  logic      run_i,
   input  logic      run_rise_i,
   input  logic      cmpa_hit_i,
   input  pin_act_e  act_q_i,
   input  logic      pin_q_i,
   input  logic      pwm_on_i,
   output logic      pin_d_o
);
   logic cmp_lvl;

   always_comb begin
      unique case (act_q_i)
         ACT_LOW:  cmp_lvl = 1'b0;
         ACT_HIGH: cmp_lvl = 1'b1;
         ACT_FLIP: cmp_lvl = ~pin_q_i;
         default:  cmp_lvl = pin_q_i;
      endcase
   end

   always_comb begin
      pin_d_o = pin_q_i;
      unique case (mode_i)
         PM_COUNT: pin_d_o = IDLE_LEVEL;
         PM_COMPARE: begin
            if (run_rise_i)                pin_d_o = lvl_cfg_i;
            else if (run_i && cmpa_hit_i)  pin_d_o = cmp_lvl;
         end
         PM_PWM: pin_d_o = pwm_on_i ? lvl_cfg_i : ~lvl_cfg_i;
         default: begin
            if (!run_i)                    pin_d_o = ~lvl_cfg_i;
            else if (run_rise_i)           pin_d_o = lvl_cfg_i;
            else if (cmpa_hit_i)           pin_d_o = ~lvl_cfg_i;
         end
      endcase
   end
endmodule

// File: rtl/tpc_pin_ctrl.sv
module tpc_pin_ctrl
   import tpc_pkg::*;
#(
   parameter bit IDLE_LEVEL = 1'b0,
   parameter bit DUTY_WINS  = 1'b1,
   parameter int MODE_BITS  = 2,
   parameter int ACT_BITS   = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [MODE_BITS-1:0] mode_i,
   input  logic [ACT_BITS-1:0]  act_i,
   input  logic                 lvl_cfg_i,
   input  logic                 run_i,
   input  logic                 cmpa_hit_i,
   input  logic                 duty_hit_i,
   input  logic                 period_hit_i,
   output logic                 pin_o
);
   generate
      if (MODE_BITS != MODE_W) begin : g_bad_mode
         $error("tpc_pin_ctrl: MODE_BITS must equal package MODE_W");
      end
      if (ACT_BITS != ACT_W) begin : g_bad_act
         $error("tpc_pin_ctrl: ACT_BITS must equal package ACT_W");
      end
   endgenerate

   pin_mode_e mode;
   pin_act_e  act_q;
   logic      run_rise;
   logic      pwm_on;
   logic      pin_d;
   logic      pin_q;

   assign mode = pin_mode_e'(mode_i);

   tpc_cfg_track u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_i),
      .act_i      (act_i),
      .act_q_o    (act_q),
      .run_rise_o (run_rise)
   );

   tpc_pwm_phase #(.DUTY_WINS(DUTY_WINS)) u_pwm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .live_i       (run_i && (mode == PM_PWM)),
      .duty_hit_i   (duty_hit_i),
      .period_hit_i (period_hit_i),
      .on_nxt_o     (pwm_on)
   );

   tpc_level_sel #(.IDLE_LEVEL(IDLE_LEVEL)) u_sel (
      .mode_i     (mode),
      .lvl_cfg_i  (lvl_cfg_i),
      .run_i      (run_i),
      .run_rise_i (run_rise),
      .cmpa_hit_i (cmpa_hit_i),
      .act_q_i    (act_q),
      .pin_q_i    (pin_q),
      .pwm_on_i   (pwm_on),
      .pin_d_o    (pin_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_q <= 1'b0;
      else         pin_q <= pin_d;
   end

   assign pin_o = pin_q;
endmodule

// File: rtl/tpc_pin_ctrl_chk.sv
module tpc_pin_ctrl_chk #(
   parameter bit IDLE_LEVEL = 1'b0
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [1:0] mode_i,
   input logic       lvl_cfg_i,
   input logic       run_i,
   input logic       cmpa_hit_i,
   input logic       duty_hit_i,
   input logic       period_hit_i,
   input logic [1:0] act_q,
   input logic       pin_o
);
   p_count_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b00) |=> (pin_o == IDLE_LEVEL));

   p_cmp_restore_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && $rose(run_i)) |=> (pin_o == $past(lvl_cfg_i)));

   p_cmp_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && run_i && !$rose(run_i) && cmpa_hit_i && act_q == 2'b10) |=> pin_o);

   p_cmp_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && run_i && !$rose(run_i) && cmpa_hit_i && act_q == 2'b01) |=> !pin_o);

   p_cmp_flip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && run_i && !$rose(run_i) && cmpa_hit_i && act_q == 2'b11) |=> (pin_o != $past(pin_o)));

   p_cmp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b01 && !run_i) |=> $stable(pin_o));

   p_act_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |=> $stable(act_q));

   p_pwm_duty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b10 && run_i && duty_hit_i && !period_hit_i) |=> (pin_o == !$past(lvl_cfg_i)));

   p_pwm_period_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b10 && run_i && period_hit_i && !duty_hit_i) |=> (pin_o == $past(lvl_cfg_i)));

   p_pwm_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b10 && !run_i) |=> (pin_o == !$past(lvl_cfg_i)));

   p_pulse_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b11 && $rose(run_i)) |=> (pin_o == $past(lvl_cfg_i)));

   p_pulse_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'b11 && !run_i) |=> (pin_o == !$past(lvl_cfg_i)));

   always @(posedge clk_i) begin
      if (!rst_ni) begin
         p_reset_r10: assert (pin_o == 1'b0 && act_q == 2'b00);
      end
   end
endmodule

bind tpc_pin_ctrl tpc_pin_ctrl_chk #(.IDLE_LEVEL(IDLE_LEVEL)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .mode_i       (mode_i),
   .lvl_cfg_i    (lvl_cfg_i),
   .run_i        (run_i),
   .cmpa_hit_i   (cmpa_hit_i),
   .duty_hit_i   (duty_hit_i),
   .period_hit_i (period_hit_i),
   .act_q        (act_q),
   .pin_o        (pin_o)
);

// File: tb/tpc_pin_ctrl_tb.sv
`timescale 1ns/1ps
module tpc_pin_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [1:0] act = 2'b00;
   logic       lvl = 1'b0;
   logic       run = 1'b0;
   logic       ca = 1'b0;
   logic       dh = 1'b0;
   logic       ph = 1'b0;
   logic       pin;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // requirement-level model state
   logic       m_pin = 1'b0;
   logic [1:0] m_act = 2'b00;
   logic       m_run = 1'b0;
   logic       m_on  = 1'b0;

   always #5 clk = ~clk;

   tpc_pin_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .act_i(act), .lvl_cfg_i(lvl),
      .run_i(run), .cmpa_hit_i(ca), .duty_hit_i(dh), .period_hit_i(ph), .pin_o(pin)
   );

   task automatic check(input logic got, input logic exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: pin=%b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic next_pin(input logic [1:0] md, input logic c, input logic e,
                                     input logic hit, input logic on_n);
      logic rise;
      rise = e && !m_run;
      case (md)
         2'b00: return 1'b0;
         2'b01: begin
            if (rise) return c;
            if (e && hit) begin
               case (m_act)
                  2'b01: return 1'b0;
                  2'b10: return 1'b1;
                  2'b11: return !m_pin;
                  default: return m_pin;
               endcase
            end
            return m_pin;
         end
         2'b10: return on_n ? c : !c;
         default: begin
            if (!e) return !c;
            if (rise) return c;
            if (hit) return !c;
            return m_pin;
         end
      endcase
   endfunction

   task automatic step(input logic [1:0] md, input logic [1:0] ac, input logic c,
                       input logic e, input logic hit, input logic d, input logic p,
                       input string tag);
      logic on_n;
      logic exp;
      @(negedge clk);
      mode = md; act = ac; lvl = c; run = e; ca = hit; dh = d; ph = p;
      on_n = (md == 2'b10 && e) ? (d ? 1'b0 : (p ? 1'b1 : m_on)) : 1'b0;
      exp  = next_pin(md, c, e, hit, on_n);
      if (tag == "R11") begin
         #2;
         check(pin, m_pin, "R11 before edge");
      end
      if (!e) m_act = ac;
      m_run = e;
      m_on  = on_n;
      m_pin = exp;
      @(posedge clk);
      #1;
      check(pin, exp, tag);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, pin=%b expected end of test", pin);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [1:0] rm;
      logic       re;
      void'($urandom(32'd7321));
      repeat (3) @(posedge clk);
      #1;
      check(pin, 1'b0, "R10 reset pin");
      @(negedge clk);
      rst_n = 1'b1;

      // R1: count-only mode ignores everything
      step(2'b00, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R1");
      step(2'b00, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R1");

      // R2/R3: compare, arm high action, start low
      step(2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      step(2'b01, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R2 rise beats match");
      step(2'b01, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 drive high");
      // R6: change action while running -> still high action
      step(2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 frozen action");
      // R5: idle ignores matches, arms low
      step(2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 idle hold");
      step(2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 restore high");
      step(2'b01, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R11");
      step(2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      // R4: high action with initial high -> no change
      step(2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      step(2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
      step(2'b01, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 same level high");
      step(2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      step(2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
      step(2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 same level low");
      // toggle and keep
      step(2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      step(2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
      step(2'b01, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 flip up");
      step(2'b01, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 flip down");
      step(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      step(2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
      step(2'b01, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R3 keep");

      // R7/R8: pulse-width, both polarities
      for (int pol = 0; pol < 2; pol++) begin
         step(2'b10, 2'b00, pol[0], 1'b0, 1'b0, 1'b0, 1'b1, "R8 disabled");
         step(2'b10, 2'b00, pol[0], 1'b1, 1'b0, 1'b0, 1'b1, "R7 period");
         step(2'b10, 2'b00, pol[0], 1'b1, 1'b0, 1'b0, 1'b0, "R7 hold active");
         step(2'b10, 2'b00, pol[0], 1'b1, 1'b0, 1'b1, 1'b0, "R7 duty");
         step(2'b10, 2'b00, pol[0], 1'b1, 1'b0, 1'b0, 1'b1, "R7 period again");
         step(2'b10, 2'b00, pol[0], 1'b1, 1'b0, 1'b1, 1'b1, "R7 coincident");
      end

      // R9: single pulse
      step(2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle");
      step(2'b11, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 start");
      step(2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 hold");
      step(2'b11, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 end");
      step(2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 idle low pol");
      step(2'b11, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 start low");

      // random mix
      rm = 2'b01;
      re = 1'b0;
      for (int i = 0; i < 6000; i++) begin
         string tg;
         if ($urandom_range(0, 39) == 0) rm = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 7) == 0)  re = ~re;
         case (rm)
            2'b00: tg = "R1 random";
            2'b01: tg = "R3 random";
            2'b10: tg = "R7 random";
            default: tg = "R9 random";
         endcase
         step(rm, 2'($urandom_range(0, 3)), ($urandom_range(0, 15) == 0) ? ~lvl : lvl, re,
              ($urandom_range(0, 4) == 0), ($urandom_range(0, 5) == 0),
              ($urandom_range(0, 5) == 0), tg);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule